// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline whose fetch stage always runs ahead on the sequential path. The operands reaching it are already forwarded. It compares them and adds the scaled immediate to the incremented PC. It then tells fetch whether to keep the fall-through address or jump to the computed target.

A branch that is not taken costs nothing: the next PC stays at the incremented PC. A taken branch redirects fetch and flushes the IF/ID register in the same cycle. The single instruction fetched behind the branch becomes a bubble. That slot is reported on the cycle after the redirect, and any branch decoded in the slot is ignored. When decode is stalled because operands are not ready yet, the unit stays silent.

Top module: `br_resolve_id`

## Requirements
- R1: While reset is low, and on the first cycle after it, `slot_bubble` is 0. With no valid instruction presented, `redirect` and `flush_ifid` are 0 and `next_pc` equals `pc_plus4`.
- R2: For an equal-compare branch (`br_kind` = 2'b01) with `op_a == op_b`, `redirect` and `flush_ifid` are 1 and `next_pc` equals `br_target`. `br_target` is `pc_plus4 + sext(imm) * 4`.
- R3: For an equal-compare branch with `op_a != op_b`, `redirect` and `flush_ifid` are 0 and `next_pc` equals `pc_plus4`.
- R4: For a nonzero-test branch (`br_kind` = 2'b10), the branch is taken exactly when `op_a != 0`, and `op_b` has no effect on the outcome.
- R5: The 16-bit `imm` is sign-extended, so a negative offset yields a target below `pc_plus4`. With `BYTE_OFS` = 0 the offset counts words and is shifted left by 2.
- R6: While `id_stall` is 1, `redirect` and `flush_ifid` are 0 whatever the operands are.
- R7: `br_kind` values 2'b00 (not a branch) and 2'b11 (reserved) never assert `redirect` or `flush_ifid`.
- R8: `flush_ifid` is asserted in the same cycle as `redirect`. `slot_bubble` is 1 on exactly the next cycle, so a taken branch costs one cycle.
- R9: While `slot_bubble` is 1, a branch in decode is ignored: `redirect` and `flush_ifid` are 0 and `next_pc` equals `pc_plus4`.
- R10: When `id_valid` is 0, `redirect` and `flush_ifid` stay 0 even if the branch condition holds.
- R11: `br_target` follows its formula on every cycle, whether or not the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_stall | input | 1 | Decode is stalled because operands are not ready |
| br_kind | input | 2 | 00 none, 01 branch if equal, 10 branch if nonzero, 11 reserved |
| op_a | input | 32 | First forwarded operand |
| op_b | input | 32 | Second forwarded operand |
| pc_plus4 | input | 32 | Address of the sequential successor |
| imm | input | 16 | Branch offset field |
| redirect | output | 1 | Fetch takes `br_target` |
| next_pc | output | 32 | Address fetch uses next |
| br_target | output | 32 | Computed branch destination |
| flush_ifid | output | 1 | Clears the IF/ID register at the coming edge |
| slot_bubble | output | 1 | Decode slot holds the squashed successor |

## Verification
The equal-compare branch is run with matching and differing operands, which separates a comparator that checks equality from one that ignores `op_b`. The nonzero test is run with a zero `op_a` against a nonzero `op_b`, and the reverse, which shows whether the wrong operand is read. Positive and negative offsets show whether the sign extension and the word scaling are right. Back-to-back taken branches, and branches presented while stalled, invalid or non-branch, show whether the single-slot squash and the gating are correct.

// File: rtl/br_resolve_id.sv
module br_resolve_id #(
  parameter int XLEN     = 32,
  parameter int IMMW     = 16,
  parameter bit BYTE_OFS = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic            id_stall,
  input  logic [1:0]      br_kind,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [IMMW-1:0] imm,
  output logic            redirect,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] br_target,
  output logic            flush_ifid,
  output logic            slot_bubble
);
  localparam int SH = BYTE_OFS ? 0 : 2;
  localparam logic [1:0] K_EQ = 2'b01;
  localparam logic [1:0] K_NZ = 2'b10;

  logic [XLEN-1:0] ofs;
  logic            cond, taken, bub_q;

  assign ofs       = {{(XLEN-IMMW){imm[IMMW-1]}}, imm} << SH;
  assign br_target = pc_plus4 + ofs;

  always_comb begin
    case (br_kind)
      K_EQ:    cond = (op_a == op_b);
      K_NZ:    cond = |op_a;
      default: cond = 1'b0;
    endcase
  end

  assign taken       = id_valid && !id_stall && !bub_q && cond;
  assign redirect    = taken;
  assign flush_ifid  = taken;
  assign next_pc     = taken ? br_target : pc_plus4;
  assign slot_bubble = bub_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bub_q <= 1'b0;
    else        bub_q <= taken;
  end

  p_bubble_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> slot_bubble);
  p_bubble_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bubble |=> !slot_bubble);
  p_bubble_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bubble |-> !redirect && !flush_ifid);
  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall |-> !redirect && !flush_ifid);
  p_nonbranch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b00 || br_kind == 2'b11) |-> !redirect);
  p_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !flush_ifid);
  p_fallthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b01 && op_a != op_b) |-> next_pc == pc_plus4);
endmodule

// File: tb/sim_br_resolve_id.sv
module sim_br_resolve_id;
  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid = 1'b0, id_stall = 1'b0;
  logic [1:0] br_kind = 2'b00;
  logic [31:0] op_a = '0, op_b = '0, pc_plus4 = '0;
  logic [15:0] imm = '0;
  logic redirect, flush_ifid, slot_bubble;
  logic [31:0] next_pc, br_target;

  int checks = 0, fails = 0;
  logic eb = 1'b0;
  logic [66:0] q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  br_resolve_id u0 (.clk, .rst_n, .id_valid, .id_stall, .br_kind, .op_a, .op_b,
    .pc_plus4, .imm, .redirect, .next_pc, .br_target, .flush_ifid, .slot_bubble);

  task automatic drv(input logic v, input logic s, input logic [1:0] k,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] p4, input logic [15:0] im, input string tag);
    logic cond, tk;
    logic [31:0] tgt;
    @(negedge clk);
    id_valid = v; id_stall = s; br_kind = k; op_a = a; op_b = b; pc_plus4 = p4; imm = im;
    tgt  = p4 + 32'($signed(im)) * 32'sd4;
    cond = (k == 2'b01) ? (a == b) : (k == 2'b10) ? (a != 0) : 1'b0;
    tk   = v && !s && !eb && cond;
    q_exp.push_back({tk, tk, eb, tk ? tgt : p4, tgt});
    q_tag.push_back(tag);
    eb = tk;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic [66:0] e, got;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        got = {redirect, flush_ifid, slot_bubble, next_pc, br_target};
        checks++;
        if (got !== e) begin
          fails++;
          $display("FAIL %s: got rd=%0b fl=%0b bub=%0b npc=%h tgt=%h expected rd=%0b fl=%0b bub=%0b npc=%h tgt=%h",
            t, got[66], got[65], got[64], got[63:32], got[31:0],
            e[66], e[65], e[64], e[63:32], e[31:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (slot_bubble !== 1'b0 || redirect !== 1'b0) begin
      fails++;
      $display("FAIL R1: got bub=%0b rd=%0b expected 0 0 in reset", slot_bubble, redirect);
    end
    @(negedge clk); rst_n = 1'b1;
    drv(0, 0, 2'b00, 0, 0, 32'h1000_0004, 16'h0019, "R1 idle after reset");
    drv(1, 0, 2'b01, 32'h55, 32'h55, 32'h1000_0004, 16'h0019, "R2 beq equal taken");
    drv(1, 0, 2'b01, 32'h7, 32'h7, 32'h1000_0008, 16'h0004, "R9 branch in bubble ignored");
    drv(1, 0, 2'b01, 32'h7, 32'h8, 32'h2000_0000, 16'h0010, "R3 beq unequal");
    drv(1, 0, 2'b10, 32'h0, 32'h9, 32'h2000_0004, 16'h0010, "R4 bnez zero a");
    drv(1, 0, 2'b10, 32'h1, 32'h0, 32'h2000_0008, 16'h0003, "R4 bnez nonzero a");
    drv(0, 0, 2'b00, 0, 0, 32'h2000_000c, 16'h0000, "R8 bubble one cycle");
    drv(0, 0, 2'b00, 0, 0, 32'h2000_0010, 16'h0000, "R8 bubble cleared");
    drv(1, 0, 2'b01, 32'hA, 32'hA, 32'h1000_0004, 16'hFFFE, "R5 negative offset");
    drv(1, 0, 2'b01, 32'hA, 32'hA, 32'h1000_0008, 16'h8000, "R9 bubble slot");
    drv(1, 1, 2'b01, 32'h3, 32'h3, 32'h3000_0000, 16'h0020, "R6 stalled beq");
    drv(1, 1, 2'b10, 32'h3, 32'h0, 32'h3000_0000, 16'h0020, "R6 stalled bnez");
    drv(1, 0, 2'b01, 32'h3, 32'h3, 32'h3000_0000, 16'h0020, "R6 stall released");
    drv(1, 0, 2'b00, 32'h4, 32'h4, 32'h4000_0000, 16'h0001, "R7 no branch");
    drv(1, 0, 2'b00, 32'h4, 32'h4, 32'h4000_0004, 16'h0001, "R7 kind none");
    drv(1, 0, 2'b11, 32'h4, 32'h4, 32'h4000_0008, 16'h0001, "R7 kind reserved");
    drv(0, 0, 2'b01, 32'h6, 32'h6, 32'h5000_0000, 16'h0002, "R10 invalid beq");
    drv(0, 0, 2'b10, 32'h6, 32'h0, 32'h5000_0004, 16'h0002, "R10 invalid bnez");
    drv(1, 0, 2'b01, 32'h1, 32'h2, 32'h6000_0000, 16'h7FFF, "R11 target not taken");
    drv(1, 0, 2'b10, 32'hFFFF_FFFF, 32'h0, 32'h6000_0004, 16'hFFFF, "R4 bnez all ones");
    drv(1, 0, 2'b10, 32'hFFFF_FFFF, 32'h0, 32'h6000_0008, 16'hFFFF, "R9 bnez in bubble");
    drv(1, 0, 2'b01, 32'h0, 32'h0, 32'h6000_000c, 16'h0000, "R2 zero offset taken");
    drv(0, 0, 2'b00, 0, 0, 32'h6000_0010, 16'h0000, "R8 final bubble");
    @(negedge clk);
    @(negedge clk);
    #4;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule